// File: doc/BRIEF.md
# Burst AMI transmit framer

This block forms one time-compressed line burst and sends it as ternary alternate-mark-inversion symbols. The burst holds the two bearer bytes and the two signalling bits of two consecutive 8 kHz frames. When a burst-start strobe arrives while the block is idle, it captures the parallel channel data. It then sends one symbol per symbol-rate enable: an unscrambled start mark first, then 36 scrambled payload bits.

A wake-up select replaces the payload with all ones, which are still scrambled, for use during loop activation. An alternate-slot select makes the block accept only every second strobe. This lets an end that starts activation on its own send wake-up bursts at half the normal burst rate. The line polarity and the scrambler state carry over from one burst to the next, so the whole stream is one continuous AMI sequence.

Top module: `burst_ami_tx`

## Requirements
- R1: `sym_o` uses 2'b01 for a positive mark, 2'b10 for a negative mark and 2'b00 for a space. The value 2'b11 never appears.
- R2: Out of reset, `busy_o` is 0 and `sym_o` is space. Whenever `busy_o` is 0, `sym_o` is space.
- R3: A high `burst_start_i` in a cycle where `busy_o` is 0 (and the slot is taken, see R9) sets `busy_o` at that clock edge. The next 37 clock edges with `sym_en_i` high each put one symbol on `sym_o`. The 38th such edge sets `sym_o` to space and clears `busy_o`.
- R4: The first symbol of every burst is a mark and is never scrambled. Its polarity is opposite to the last mark sent before it. The first mark after reset is positive.
- R5: Each later line bit of 1 is sent as a mark whose polarity is opposite to the previous mark. A line bit of 0 is sent as a space.
- R6: The payload order is: frame-A byte 1 (MSB first), frame-A byte 2 (MSB first), frame-A signalling bits (bit 1 first), then the same 18-bit group for frame B.
- R7: The line bit for each payload bit p is p ^ s[n-5] ^ s[n-9], where s is the history of line bits. The nine-bit history starts at all ones after reset. It advances only on payload bits and is kept from one burst to the next.
- R8: With `wake_i` high at the accepting strobe, every payload bit is 1 before scrambling, and the data inputs are ignored.
- R9: While `alt_slot_i` is high, the block starts a burst on the first idle strobe and skips the second, then repeats. A skipped strobe leaves `busy_o` low and `sym_o` at space. A strobe with `alt_slot_i` low is always taken.
- R10: A strobe while `busy_o` is high has no effect on the symbols of the current burst, and no burst follows it.
- R11: `sym_o` changes only at clock edges where `sym_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_en_i | input | 1 | Symbol-rate enable, one pulse per line symbol |
| burst_start_i | input | 1 | Burst-start strobe |
| wake_i | input | 1 | Send an all-ones activation payload |
| alt_slot_i | input | 1 | Accept only every second strobe |
| b1_a_i | input | 8 | Frame A, bearer byte 1 |
| b2_a_i | input | 8 | Frame A, bearer byte 2 |
| d_a_i | input | 2 | Frame A, signalling bits |
| b1_b_i | input | 8 | Frame B, bearer byte 1 |
| b2_b_i | input | 8 | Frame B, bearer byte 2 |
| d_b_i | input | 2 | Frame B, signalling bits |
| sym_o | output | 2 | Line symbol code |
| busy_o | output | 1 | Burst in progress |

## Verification
The bound checker watches four things on every cycle:
- that the code 2'b11 never appears;
- that the output is space whenever the block is idle;
- that the output holds between symbol enables;
- that successive marks alternate in polarity, counted across bursts.

It also checks that a busy period starts only from a strobe. The exact symbol values can only be shown by the directed scenarios. These compare each burst against a model of the scrambler and polarity built from the requirements. The scenarios also cover the start-mark continuation, the payload order, the wake pattern, alternate-slot skipping, and strobes that arrive mid-burst.

// File: rtl/burst_ami_pkg.sv
package burst_ami_pkg;
  typedef enum logic [1:0] {
    SYM_SPACE = 2'b00,
    SYM_POS   = 2'b01,
    SYM_NEG   = 2'b10
  } sym_e;
endpackage

// File: rtl/burst_payload.sv
module burst_payload #(
  parameter int CH_W = 8,
  parameter int D_W  = 2,
  localparam int PAY_W = 2 * (2 * CH_W + D_W)
) (
  input  logic            wake_i,
  input  logic [CH_W-1:0] b1_a_i,
  input  logic [CH_W-1:0] b2_a_i,
  input  logic [D_W-1:0]  d_a_i,
  input  logic [CH_W-1:0] b1_b_i,
  input  logic [CH_W-1:0] b2_b_i,
  input  logic [D_W-1:0]  d_b_i,
  output logic [PAY_W-1:0] word_o
);
  // MSB of word_o leaves the line first
  always_comb begin
    if (wake_i) word_o = '1;
    else        word_o = {b1_a_i, b2_a_i, d_a_i, b1_b_i, b2_b_i, d_b_i};
  end
endmodule

// File: rtl/burst_scrambler.sv
module burst_scrambler #(
  parameter int          LEN  = 9,
  parameter int          TAP  = 5,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic bit_i,
  output logic bit_o
);
  logic [LEN-1:0] hist_q;

  // self-synchronizing: feedback taken from sent bits
  assign bit_o = bit_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= SEED;
    else if (adv_i) hist_q <= {hist_q[LEN-2:0], bit_o};
  end
endmodule

// File: rtl/ami_encoder.sv
module ami_encoder
  import burst_ami_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       valid_i,
  input  logic       bit_i,
  output logic [1:0] sym_o
);
  sym_e sym_q;
  logic last_neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q      <= SYM_SPACE;
      last_neg_q <= 1'b1;
    end else if (tick_i) begin
      if (valid_i && bit_i) begin
        sym_q      <= last_neg_q ? SYM_POS : SYM_NEG;
        last_neg_q <= ~last_neg_q;
      end else begin
        sym_q <= SYM_SPACE;
      end
    end
  end

  assign sym_o = sym_q;
endmodule

// File: rtl/burst_ami_tx.sv
module burst_ami_tx #(
  parameter int       CH_W    = 8,
  parameter int       D_W     = 2,
  parameter int       SCR_LEN = 9,
  parameter int       SCR_TAP = 5,
  parameter logic [SCR_LEN-1:0] SCR_SEED = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sym_en_i,
  input  logic            burst_start_i,
  input  logic            wake_i,
  input  logic            alt_slot_i,
  input  logic [CH_W-1:0] b1_a_i,
  input  logic [CH_W-1:0] b2_a_i,
  input  logic [D_W-1:0]  d_a_i,
  input  logic [CH_W-1:0] b1_b_i,
  input  logic [CH_W-1:0] b2_b_i,
  input  logic [D_W-1:0]  d_b_i,
  output logic [1:0]      sym_o,
  output logic            busy_o
);
  localparam int PAY_W = 2 * (2 * CH_W + D_W);
  localparam int NSYM  = PAY_W + 1;
  localparam int CNT_W = $clog2(NSYM + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NSYM);

  logic [PAY_W-1:0] word, pay_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, phase_q;
  logic             take, emit, is_start, scr_bit, line_bit;

  burst_payload #(.CH_W(CH_W), .D_W(D_W)) u_pay (
    .wake_i (wake_i),
    .b1_a_i (b1_a_i), .b2_a_i (b2_a_i), .d_a_i (d_a_i),
    .b1_b_i (b1_b_i), .b2_b_i (b2_b_i), .d_b_i (d_b_i),
    .word_o (word)
  );

  assign take     = !alt_slot_i || !phase_q;
  assign emit     = busy_q && sym_en_i && (cnt_q != LAST);
  assign is_start = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      pay_q   <= '0;
    end else if (!busy_q) begin
      if (burst_start_i) begin
        phase_q <= alt_slot_i ? ~phase_q : 1'b0;
        if (take) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          pay_q  <= word;
        end
      end
    end else if (sym_en_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (!is_start) pay_q <= {pay_q[PAY_W-2:0], 1'b0};
      end
    end
  end

  burst_scrambler #(.LEN(SCR_LEN), .TAP(SCR_TAP), .SEED(SCR_SEED)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (emit && !is_start),
    .bit_i  (pay_q[PAY_W-1]),
    .bit_o  (scr_bit)
  );

  // start bit bypasses the scrambler and is always a mark
  assign line_bit = is_start ? 1'b1 : scr_bit;

  ami_encoder u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sym_en_i),
    .valid_i (emit),
    .bit_i   (line_bit),
    .sym_o   (sym_o)
  );

  assign busy_o = busy_q;
endmodule

// File: rtl/burst_ami_tx_chk.sv
module burst_ami_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sym_en_i,
  input logic       burst_start_i,
  input logic [1:0] sym_o,
  input logic       busy_o
);
  logic en_d, last_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_d     <= 1'b0;
      last_pos <= 1'b0;
    end else begin
      en_d <= sym_en_i;
      if (en_d && sym_o != 2'b00) last_pos <= (sym_o == 2'b01);
    end
  end

  // R1
  no_bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_o != 2'b11);

  // R2
  idle_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sym_o == 2'b00);

  // R11
  hold_sym_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_en_i |=> $stable(sym_o));

  // R5
  alt_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_d && sym_o == 2'b01) |-> !last_pos);

  // R5
  alt_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_d && sym_o == 2'b10) |-> last_pos);

  // R3
  start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(burst_start_i));
endmodule

bind burst_ami_tx burst_ami_tx_chk u_chk (.*);

// File: tb/burst_ami_tx_test.sv
`timescale 1ns/1ps
module burst_ami_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_en = 1'b0, strobe = 1'b0, wake = 1'b0, alt = 1'b0;
  logic [7:0] b1a = '0, b2a = '0, b1b = '0, b2b = '0;
  logic [1:0] da = '0, db = '0;
  logic [1:0] sym;
  logic busy;

  int total = 0, bad = 0;
  logic [8:0] m_hist = 9'h1FF;
  logic m_lastneg = 1'b1;
  logic en_gate = 1'b1;
  int div = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div = (div + 1) % 4;
    sym_en = en_gate && (div == 0);
  end

  burst_ami_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_en_i(sym_en), .burst_start_i(strobe),
    .wake_i(wake), .alt_slot_i(alt),
    .b1_a_i(b1a), .b2_a_i(b2a), .d_a_i(da),
    .b1_b_i(b1b), .b2_b_i(b2b), .d_b_i(db),
    .sym_o(sym), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mark_model();
    logic [1:0] s;
    s = m_lastneg ? 2'b01 : 2'b10;
    m_lastneg = ~m_lastneg;
    return s;
  endfunction

  // builds the expected 38 symbols and advances the model (R4 R5 R6 R7 R8)
  task automatic expect_burst(input logic [35:0] word, output logic [1:0] ex [38]);
    ex[0] = mark_model();
    for (int k = 0; k < 36; k++) begin
      logic p, s;
      p = word[35-k];
      s = p ^ m_hist[4] ^ m_hist[8];
      m_hist = {m_hist[7:0], s};
      ex[k+1] = s ? mark_model() : 2'b00;
    end
    ex[37] = 2'b00;
  endtask

  task automatic pulse_strobe();
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic run_burst(input logic [7:0] x1a, x2a, input logic [1:0] xda,
                           input logic [7:0] x1b, x2b, input logic [1:0] xdb,
                           input bit wk, input bit pause, input bit poke, input string req);
    logic [1:0] ex [38];
    logic [35:0] w;
    logic [1:0] held;
    w = wk ? '1 : {x1a, x2a, xda, x1b, x2b, xdb};
    expect_burst(w, ex);
    @(negedge clk);
    b1a = x1a; b2a = x2a; da = xda; b1b = x1b; b2b = x2b; db = xdb; wake = wk;
    pulse_strobe();
    check(busy === 1'b1, "R3 busy after strobe", busy, 1);
    for (int n = 0; n < 38; ) begin
      @(posedge clk);
      if (sym_en) begin
        @(negedge clk);
        check(sym === ex[n], req, sym, ex[n]);
        if (n == 0) check(sym !== 2'b00, "R4 start mark", sym, ex[0]);
        n++;
        if (poke && n == 5) begin
          b1a = ~x1a; wake = 1'b0;
          pulse_strobe();
        end
        if (pause && n == 10) begin
          held = sym;
          en_gate = 1'b0;
          repeat (20) @(negedge clk);
          check(sym === held, "R11 hold without enable", sym, held);
          en_gate = 1'b1;
        end
      end
    end
    check(busy === 1'b0, "R3 busy clears after 37 symbols", busy, 0);
    wake = 1'b0;
  endtask

  task automatic t_reset();
    check(sym === 2'b00, "R2 reset sym", sym, 0);
    check(busy === 1'b0, "R2 reset busy", busy, 0);
  endtask

  task automatic t_data();
    run_burst(8'hA5, 8'h3C, 2'b10, 8'h0F, 8'hF0, 2'b01, 0, 0, 0, "R6 R7 data burst 1");
    run_burst(8'h00, 8'h00, 2'b00, 8'h00, 8'h00, 2'b00, 0, 0, 0, "R5 R7 zero payload");
    run_burst(8'hFF, 8'h81, 2'b11, 8'h7E, 8'h01, 2'b10, 0, 0, 0, "R4 R6 data burst 3");
  endtask

  task automatic t_idle();
    repeat (16) @(negedge clk);
    check(sym === 2'b00 && busy === 1'b0, "R2 idle space between bursts", sym, 0);
  endtask

  task automatic t_wake();
    run_burst(8'h12, 8'h34, 2'b01, 8'h56, 8'h78, 2'b10, 1, 0, 0, "R8 wake payload");
  endtask

  task automatic t_alt();
    alt = 1'b1;
    run_burst(8'hC3, 8'h5A, 2'b01, 8'h99, 8'h66, 2'b11, 1, 0, 0, "R9 first slot taken");
    @(negedge clk);
    wake = 1'b1;
    pulse_strobe();
    repeat (12) @(negedge clk);
    check(busy === 1'b0, "R9 second slot skipped busy", busy, 0);
    check(sym === 2'b00, "R9 second slot skipped sym", sym, 0);
    wake = 1'b0;
    run_burst(8'h11, 8'h22, 2'b10, 8'h33, 8'h44, 2'b01, 1, 0, 0, "R9 third slot taken");
    alt = 1'b0;
    run_burst(8'h55, 8'hAA, 2'b00, 8'h5A, 8'hA5, 2'b11, 0, 0, 0, "R9 alt off taken");
    run_burst(8'h66, 8'h99, 2'b01, 8'h69, 8'h96, 2'b10, 0, 0, 0, "R9 alt off taken again");
  endtask

  task automatic t_busy_strobe();
    run_burst(8'h4D, 8'hB2, 2'b11, 8'h2B, 8'hD4, 2'b00, 0, 0, 1, "R10 strobe mid-burst");
    repeat (12) @(negedge clk);
    check(busy === 1'b0, "R10 no burst after mid-burst strobe", busy, 0);
  endtask

  task automatic t_hold();
    run_burst(8'hE7, 8'h18, 2'b10, 8'hBD, 8'h42, 2'b01, 0, 1, 0, "R11 R1 paused burst");
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_data();
    t_idle();
    t_wake();
    t_alt();
    t_busy_strobe();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule